// File: doc/BRIEF.md
# Quad-Channel Double-Buffered DAC Code Registers

This block is the digital front end of a four-channel, 12-bit converter. A parallel bus with a 2-bit channel address, a read/write select, an active-low select and 12-bit write data stages new codes into a first rank of per-channel staging registers. A second rank of output registers feeds the converters. A global active-low load strobe moves all staged codes into the output rank at once. Holding the load strobe low makes the output rank follow the staging rank, so a write reaches its output on the same clock edge.

Both ranks are modelled synchronously. A register that would be transparent in a latch design takes its new value at the next rising clock edge. A functional clear input, active low, overrides every other bus input and forces both ranks to a reset code. The parameter `RESET_MIDSCALE` picks that code: mid-scale 0x800 or zero. A read cycle returns the addressed staging register on a dedicated output with a valid flag, instead of driving a bidirectional bus. Codes are straight binary, so the converter output is VREFL + (VREFH − VREFL)·N/4096.

Top module: `dacif_quad`

## Requirements
- R1: While `rst` is high or `clr_n` is low at a clock edge, every staging and output register takes the reset code, whatever `cs_n`, `rd_wr`, `addr` and `load_n` are doing. The reset code is 0x800 when `RESET_MIDSCALE`=1 and 0x000 when it is 0.
- R2: On an edge with `cs_n`=0, `rd_wr`=0 and `clr_n`=1, the staging register for channel `addr` takes `wdata`. Channel 0 is A, 1 is B, 2 is C and 3 is D.
- R3: At most one staging register changes per edge. When `cs_n`=1, no staging register changes.
- R4: With `cs_n`=0 and `rd_wr`=1, `rd_valid` is 1 in the same cycle and `rd_data` equals the staging register of channel `addr`. No staging register changes.
- R5: When `cs_n`=1 or `rd_wr`=0, `rd_valid` is 0 and `rd_data` is 0.
- R6: While `load_n`=1 and no clear is active, every output register holds its value.
- R7: On an edge with `load_n`=0, each output register takes its channel's staging value. If that same edge writes a channel, the output register for that channel takes the written word.
- R8: After a clear ends, any register that is neither written nor loaded keeps the reset code.
- R9: Channel i drives `dac_code[12*i+11:12*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; acts like a clear |
| clr_n | input | 1 | Active-low functional clear; highest priority |
| cs_n | input | 1 | Active-low bus select |
| rd_wr | input | 1 | 1 = read back, 0 = write |
| addr | input | 2 | Channel address (0..3 = A..D) |
| wdata | input | 12 | Code to write |
| load_n | input | 1 | Active-low global load into the output rank |
| dac_code | output | 48 | Four output codes, channel i at bits 12i+11:12i |
| rd_data | output | 12 | Readback code of the addressed staging register |
| rd_valid | output | 1 | Readback valid |

## Verification
The bound checker checks several rules on every cycle: a clear forces the reset pattern onto the outputs, and the outputs hold while the load strobe is high. It also checks that the staging rank stays still during idle and read cycles, that the readback valid flag drops when the block is deselected, and that a load with the bus idle copies the staging rank exactly. Some behaviour only the directed scenarios can show. These are the per-channel address decode, same-edge flow-through of a write with the load held low, readback of the right channel, the zero-code variant, and reset codes that survive after a clear when nothing is loaded.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

    localparam int CODE_W = 12;
    localparam int ADDR_W = 2;
    localparam int NUM_CH = 1 << ADDR_W;
    localparam int BUS_W  = NUM_CH * CODE_W;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [ADDR_W-1:0] chan_t;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_CLEAR = 2'd3
    } bus_op_e;

    typedef struct packed {
        bus_op_e op;
        chan_t   chan;
        code_t   data;
    } bus_req_t;

    function automatic code_t reset_code(input bit midscale);
        code_t c;
        c = '0;
        if (midscale) c[CODE_W-1] = 1'b1;
        return c;
    endfunction

    function automatic bus_op_e classify(input logic clear, input logic cs_n,
                                         input logic rd_wr);
        if (clear)      return OP_CLEAR;
        else if (cs_n)  return OP_IDLE;
        else if (rd_wr) return OP_READ;
        else            return OP_WRITE;
    endfunction

endpackage

// File: rtl/dacif_decode.sv
module dacif_decode
    import dacif_pkg::*;
(
    input  bus_req_t          req,
    output logic [NUM_CH-1:0] wr_en,
    output logic              rd_en,
    output logic              clear
);
    always_comb begin
        wr_en = '0;
        if (req.op == OP_WRITE) wr_en[req.chan] = 1'b1;
    end

    assign rd_en = (req.op == OP_READ);
    assign clear = (req.op == OP_CLEAR);
endmodule

// File: rtl/dacif_stage_rank.sv
module dacif_stage_rank
    import dacif_pkg::*;
#(
    parameter code_t RST_CODE = '0
) (
    input  logic              clk,
    input  logic              clear,
    input  logic [NUM_CH-1:0] wr_en,
    input  code_t             wdata,
    output logic [BUS_W-1:0]  q,
    output logic [BUS_W-1:0]  thru
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        code_t r_q;
        always_ff @(posedge clk) begin
            if (clear)         r_q <= RST_CODE;
            else if (wr_en[i]) r_q <= wdata;
        end
        assign q[i*CODE_W +: CODE_W]    = r_q;
        assign thru[i*CODE_W +: CODE_W] = wr_en[i] ? wdata : r_q;
    end
endmodule

// File: rtl/dacif_out_rank.sv
module dacif_out_rank
    import dacif_pkg::*;
#(
    parameter code_t RST_CODE = '0
) (
    input  logic             clk,
    input  logic             clear,
    input  logic             load,
    input  logic [BUS_W-1:0] src,
    output logic [BUS_W-1:0] q
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        code_t r_q;
        always_ff @(posedge clk) begin
            if (clear)     r_q <= RST_CODE;
            else if (load) r_q <= src[i*CODE_W +: CODE_W];
        end
        assign q[i*CODE_W +: CODE_W] = r_q;
    end
endmodule

// File: rtl/dacif_readback.sv
module dacif_readback
    import dacif_pkg::*;
(
    input  logic [BUS_W-1:0] stage_q,
    input  chan_t            chan,
    input  logic             rd_en,
    output code_t            rd_data
);
    assign rd_data = rd_en ? stage_q[chan*CODE_W +: CODE_W] : '0;
endmodule

// File: rtl/dacif_quad.sv
module dacif_quad
    import dacif_pkg::*;
#(
    parameter bit RESET_MIDSCALE = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          clr_n,
    input  logic                          cs_n,
    input  logic                          rd_wr,
    input  logic [dacif_pkg::ADDR_W-1:0]  addr,
    input  logic [dacif_pkg::CODE_W-1:0]  wdata,
    input  logic                          load_n,
    output logic [dacif_pkg::BUS_W-1:0]   dac_code,
    output logic [dacif_pkg::CODE_W-1:0]  rd_data,
    output logic                          rd_valid
);
    localparam code_t RST_CODE = reset_code(RESET_MIDSCALE);

    bus_req_t          req;
    logic [NUM_CH-1:0] wr_en;
    logic              rd_en;
    logic              clear;
    logic [BUS_W-1:0]  in_q;
    logic [BUS_W-1:0]  in_thru;

    always_comb begin
        req.op   = classify(rst || !clr_n, cs_n, rd_wr);
        req.chan = addr;
        req.data = wdata;
    end

    dacif_decode u_dec (
        .req   (req),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .clear (clear)
    );

    dacif_stage_rank #(.RST_CODE(RST_CODE)) u_stage (
        .clk   (clk),
        .clear (clear),
        .wr_en (wr_en),
        .wdata (req.data),
        .q     (in_q),
        .thru  (in_thru)
    );

    dacif_out_rank #(.RST_CODE(RST_CODE)) u_out (
        .clk   (clk),
        .clear (clear),
        .load  (!load_n),
        .src   (in_thru),
        .q     (dac_code)
    );

    dacif_readback u_rb (
        .stage_q (in_q),
        .chan    (req.chan),
        .rd_en   (rd_en),
        .rd_data (rd_data)
    );

    assign rd_valid = rd_en;
endmodule

// File: rtl/dacif_quad_chk.sv
module dacif_quad_chk
    import dacif_pkg::*;
#(
    parameter bit RESET_MIDSCALE = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic             clr_n,
    input logic             cs_n,
    input logic             rd_wr,
    input logic             load_n,
    input logic [BUS_W-1:0] in_q,
    input logic [BUS_W-1:0] dac_code,
    input logic             rd_valid
);
    localparam code_t            RC  = reset_code(RESET_MIDSCALE);
    localparam logic [BUS_W-1:0] ALL = {NUM_CH{RC}};

    AST_CLEAR_FORCES: assert property (@(posedge clk) disable iff (rst)
        !clr_n |=> dac_code == ALL);                                  // R1

    AST_IDLE_STAGE_STILL: assert property (@(posedge clk) disable iff (rst)
        (cs_n && clr_n) |=> $stable(in_q));                           // R3

    AST_READ_STAGE_STILL: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && rd_wr && clr_n) |=> $stable(in_q));                 // R4

    AST_RDVALID_DESELECT: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !rd_valid);                                          // R5

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (load_n && clr_n) |=> $stable(dac_code));                     // R6

    AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (rst)
        (!load_n && clr_n && cs_n) |=> dac_code == $past(in_q));      // R7
endmodule

bind dacif_quad dacif_quad_chk #(.RESET_MIDSCALE(RESET_MIDSCALE)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .clr_n    (clr_n),
    .cs_n     (cs_n),
    .rd_wr    (rd_wr),
    .load_n   (load_n),
    .in_q     (in_q),
    .dac_code (dac_code),
    .rd_valid (rd_valid)
);

// File: tb/dacif_quad_test.sv
module dacif_quad_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr_n = 1'b1;
    logic        cs_n = 1'b1;
    logic        rd_wr = 1'b0;
    logic [1:0]  addr = '0;
    logic [11:0] wdata = '0;
    logic        load_n = 1'b1;
    logic [47:0] dac_code, dac_code_z;
    logic [11:0] rd_data, rd_data_z;
    logic        rd_valid, rd_valid_z;

    int tests = 0;
    int fails = 0;
    logic [11:0] exp_in [4];
    logic [11:0] exp_out[4];

    always #4 clk = ~clk;

    dacif_quad #(.RESET_MIDSCALE(1'b1)) uut (
        .clk(clk), .rst(rst), .clr_n(clr_n), .cs_n(cs_n), .rd_wr(rd_wr),
        .addr(addr), .wdata(wdata), .load_n(load_n),
        .dac_code(dac_code), .rd_data(rd_data), .rd_valid(rd_valid));

    dacif_quad #(.RESET_MIDSCALE(1'b0)) uut_zero (
        .clk(clk), .rst(rst), .clr_n(clr_n), .cs_n(cs_n), .rd_wr(rd_wr),
        .addr(addr), .wdata(wdata), .load_n(load_n),
        .dac_code(dac_code_z), .rd_data(rd_data_z), .rd_valid(rd_valid_z));

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [47:0] exp_bus();
        return {exp_out[3], exp_out[2], exp_out[1], exp_out[0]};
    endfunction

    task automatic model_clear();
        for (int i = 0; i < 4; i++) begin
            exp_in[i]  = 12'h800;
            exp_out[i] = 12'h800;
        end
    endtask

    task automatic do_write(input int ch, input logic [11:0] d);
        cs_n = 0; rd_wr = 0; addr = 2'(ch); wdata = d;
        tick();
        cs_n = 1;
        exp_in[ch] = d;
        if (!load_n) for (int i = 0; i < 4; i++) exp_out[i] = exp_in[i];
    endtask

    task automatic do_read(input int ch, input string tag);
        cs_n = 0; rd_wr = 1; addr = 2'(ch);
        #1;
        chk({tag, " rd_valid"}, 48'(rd_valid), 48'd1);
        chk({tag, " rd_data"}, 48'(rd_data), 48'(exp_in[ch]));
        tick();
        cs_n = 1; rd_wr = 0;
    endtask

    task automatic t_reset();
        tick(); tick();
        rst = 0;
        model_clear();
        chk("R1 reset midscale", dac_code, exp_bus());
        chk("R1 reset zero variant", dac_code_z, 48'h0);
        #1;
        chk("R5 idle rd_valid", 48'(rd_valid), 48'd0);
        chk("R5 idle rd_data", 48'(rd_data), 48'd0);
    endtask

    task automatic t_write_readback();
        do_write(0, 12'h123);
        do_write(1, 12'h456);
        do_write(2, 12'hABC);
        do_write(3, 12'hFFF);
        chk("R6 outputs hold with load high", dac_code, exp_bus());
        for (int i = 0; i < 4; i++) do_read(i, "R2 R4 readback");
        cs_n = 0; rd_wr = 0; addr = 2'd1; wdata = 12'h777;
        #1;
        chk("R5 write cycle rd_valid", 48'(rd_valid), 48'd0);
        chk("R5 write cycle rd_data", 48'(rd_data), 48'd0);
        tick(); cs_n = 1; exp_in[1] = 12'h777;
        for (int i = 0; i < 4; i++) do_read(i, "R3 only addressed channel");
    endtask

    task automatic t_cs_idle();
        cs_n = 1; rd_wr = 0; addr = 2'd0; wdata = 12'h0F0;
        tick(); tick();
        do_read(0, "R3 cs high no write");
    endtask

    task automatic t_load();
        load_n = 0;
        tick();
        load_n = 1;
        for (int i = 0; i < 4; i++) exp_out[i] = exp_in[i];
        chk("R7 R9 global load", dac_code, exp_bus());
        chk("R9 channel C field", 48'(dac_code[35:24]), 48'(exp_in[2]));
        do_write(2, 12'h5A5);
        chk("R6 no update without load", dac_code, exp_bus());
    endtask

    task automatic t_flow();
        load_n = 0;
        tick();
        for (int i = 0; i < 4; i++) exp_out[i] = exp_in[i];
        do_write(3, 12'h3C3);
        chk("R7 flow-through same edge", dac_code, exp_bus());
        load_n = 1;
    endtask

    task automatic t_clear_priority();
        clr_n = 0; cs_n = 0; rd_wr = 0; addr = 2'd2; wdata = 12'h999; load_n = 0;
        tick();
        clr_n = 1; cs_n = 1; load_n = 1;
        model_clear();
        chk("R1 clear overrides write and load", dac_code, exp_bus());
        chk("R1 zero variant clear", dac_code_z, 48'h0);
        do_write(1, 12'h222);
        tick();
        chk("R8 outputs keep reset code", dac_code, exp_bus());
        do_read(0, "R8 unwritten keeps reset");
        do_read(1, "R8 written channel");
    endtask

    initial begin
        #1_600_000;
        fails++; tests++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_write_readback();
        t_cs_idle();
        t_load();
        t_flow();
        t_clear_priority();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule